// File: doc/BRIEF.md
# Quad Channel Fault Latch Controller

This block sits between the per-channel control inputs of a four-channel low-side driver and its gate drivers. Every channel has its own command input, an over-temperature sense input and an open-load sense input. All of these are synchronous to the block clock and already debounced. For each channel the block drives a gate-enable output and keeps two sticky status flags: a thermal flag and an open-load flag. The eight flags are exported together as one fault vector for a readout path that lies outside this block.

Each channel runs its own three-state machine. The states are CH_IDLE (command low, gate off), CH_DRIVE (command high, gate on) and CH_TRIP (thermal shutdown, gate off). The named transitions are:

- T_ON: CH_IDLE to CH_DRIVE when the command is high.
- T_OFF: CH_DRIVE to CH_IDLE when the command is low.
- T_HEAT: any state to CH_TRIP when thermal sense is high.
- T_REARM: CH_TRIP to CH_DRIVE on a rising edge of the command while thermal sense is low.

The thermal flag is high exactly while the channel sits in CH_TRIP. The open-load flag is a separate sticky bit. It sets only while the command is low, and it clears on the command's falling edge. Command edges are found by comparing the command with a registered copy of it.

Top module: `quad_fault_latch`

## Requirements
- R1: While rst_n is low, every gate_en bit and every fault_vec bit is 0, and the stored command copy is 0.
- R2: For a channel that is neither tripped nor seeing thermal sense, gate_en follows that channel's ch_in one clock later.
- R3: When ot_sense of a channel is high in a cycle, from the next cycle that channel's thermal flag is 1 and its gate_en is 0, whatever its ch_in.
- R4: A tripped channel stays tripped, with gate_en 0, until a cycle where ch_in is 1 after having been 0 in the previous cycle. In that cycle, if ot_sense is low, the thermal flag clears and gate_en becomes 1 on the next cycle.
- R5: When a rising edge of ch_in and ot_sense fall in the same cycle, the trip wins: the channel stays or goes to CH_TRIP.
- R6: The open-load flag of a channel sets in the cycle after ol_sense is high while that channel's ch_in is 0. While ch_in is 1, ol_sense has no effect.
- R7: The open-load flag clears in the cycle after a falling edge of ch_in. If ol_sense is high in that same cycle, the set wins and the flag stays 1.
- R8: The open-load flag never forces gate_en to 0.
- R9: Each channel's gate_en and flags depend only on that channel's own inputs.
- R10: fault_vec is {open-load flags[3:0], thermal flags[3:0]}, with channel 0 in bit 0 of each nibble (thermal flag of channel c at bit c, open-load flag at bit 4+c).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_in | input | 4 | Per-channel drive command |
| ot_sense | input | 4 | Per-channel over-temperature sense |
| ol_sense | input | 4 | Per-channel open-load sense |
| gate_en | output | 4 | Per-channel gate enable |
| fault_vec | output | 8 | {open-load flags, thermal flags} |

## Verification
Plain command toggling with no sense activity shows that the gate follows the command with one cycle of delay. Thermal pulses are applied while the command is high and then while it is low; a command that stays high without a fresh rising edge shows that the latch holds. A thermal pulse that lands exactly on a rising edge separates set priority from clear priority. Open-load sense is pulsed while the command is high and while it is low, and also on the falling-edge cycle, which tells the ignore, set and same-cycle-set cases apart. A long pseudo-random run on all four channels at once, compared every cycle against a behavioural model, shows channel independence and the vector bit layout.

// File: rtl/qfl_pkg.sv
package qfl_pkg;
    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_DRIVE = 2'd1,
        CH_TRIP  = 2'd2
    } ch_state_e;
endpackage

// File: rtl/qfl_edge_detect.sv
module qfl_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic sig_q_o,
    output logic rise_o,
    output logic fall_o
);
    logic sig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig_i;
    end

    assign sig_q_o = sig_q;
    assign rise_o  = sig_i & ~sig_q;
    assign fall_o  = ~sig_i & sig_q;
endmodule

// File: rtl/qfl_openload_flag.sv
module qfl_openload_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic ch_in,
    input  logic ol_sense,
    input  logic in_fall,
    output logic ol_flag
);
    logic set_req;

    always_comb set_req = ol_sense & ~ch_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ol_flag <= 1'b0;
        else if (set_req) ol_flag <= 1'b1;
        else if (in_fall) ol_flag <= 1'b0;
    end

    p_ol_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ch_in && ol_sense) |=> ol_flag);
    p_ol_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_in && !ol_flag) |=> !ol_flag);
    p_ol_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fall && !ol_sense) |=> !ol_flag);
endmodule

// File: rtl/qfl_channel.sv
module qfl_channel
    import qfl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ch_in,
    input  logic ot_sense,
    input  logic ol_sense,
    output logic gate_en,
    output logic ot_flag,
    output logic ol_flag
);
    ch_state_e state, state_nx;
    logic in_q, in_rise, in_fall;

    qfl_edge_detect u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (ch_in),
        .sig_q_o(in_q),
        .rise_o (in_rise),
        .fall_o (in_fall)
    );

    always_comb begin
        state_nx = state;
        if (ot_sense) begin
            state_nx = CH_TRIP;                  // T_HEAT, beats T_REARM
        end else begin
            unique case (state)
                CH_IDLE:  if (ch_in)   state_nx = CH_DRIVE;  // T_ON
                CH_DRIVE: if (!ch_in)  state_nx = CH_IDLE;   // T_OFF
                CH_TRIP:  if (in_rise) state_nx = CH_DRIVE;  // T_REARM
                default:  state_nx = CH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CH_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        gate_en = 1'b0;
        ot_flag = 1'b0;
        unique case (state)
            CH_IDLE:  ;
            CH_DRIVE: gate_en = 1'b1;
            CH_TRIP:  ot_flag = 1'b1;
            default:  ;
        endcase
    end

    qfl_openload_flag u_ol (
        .clk     (clk),
        .rst_n   (rst_n),
        .ch_in   (ch_in),
        .ol_sense(ol_sense),
        .in_fall (in_fall),
        .ol_flag (ol_flag)
    );

    p_gate_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ot_sense && !ot_flag) |=> (gate_en == $past(ch_in)));
    p_trip_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ot_sense |=> (ot_flag && !gate_en));
    p_trip_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ot_flag && !(ch_in && !in_q)) |=> (ot_flag && !gate_en));
    p_rearm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ot_flag && ch_in && !in_q && !ot_sense) |=> (gate_en && !ot_flag));
    p_ol_no_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ol_flag && ch_in && !ot_sense && !ot_flag) |=> gate_en);
endmodule

// File: rtl/quad_fault_latch.sv
module quad_fault_latch #(
    parameter int NUM_CH = 4,
    localparam int VEC_W = 2 * NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ch_in,
    input  logic [NUM_CH-1:0] ot_sense,
    input  logic [NUM_CH-1:0] ol_sense,
    output logic [NUM_CH-1:0] gate_en,
    output logic [VEC_W-1:0]  fault_vec
);
    logic [NUM_CH-1:0] ot_flags, ol_flags;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        qfl_channel u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .ch_in   (ch_in[c]),
            .ot_sense(ot_sense[c]),
            .ol_sense(ol_sense[c]),
            .gate_en (gate_en[c]),
            .ot_flag (ot_flags[c]),
            .ol_flag (ol_flags[c])
        );
    end

    assign fault_vec = {ol_flags, ot_flags};

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_in == '0 && ot_sense == '0) |=> (gate_en == '0));
endmodule

// File: tb/quad_fault_latch_tb.sv
module quad_fault_latch_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ch_in = '0, ot_sense = '0, ol_sense = '0;
    logic [3:0] gate_en;
    logic [7:0] fault_vec;

    int vectors = 0, errors = 0;
    bit done = 0;

    int m_q[4], m_trip[4], m_ol[4], m_gate[4];

    always #4 clk = ~clk;

    quad_fault_latch dut_i (
        .clk(clk), .rst_n(rst_n), .ch_in(ch_in), .ot_sense(ot_sense),
        .ol_sense(ol_sense), .gate_en(gate_en), .fault_vec(fault_vec)
    );

    function automatic void model_clear();
        for (int c = 0; c < 4; c++) begin
            m_q[c] = 0; m_trip[c] = 0; m_ol[c] = 0; m_gate[c] = 0;
        end
    endfunction

    function automatic void model_tick(logic [3:0] i, logic [3:0] t, logic [3:0] o);
        for (int c = 0; c < 4; c++) begin
            int rise, fall;
            rise = (i[c] && m_q[c] == 0) ? 1 : 0;
            fall = (!i[c] && m_q[c] == 1) ? 1 : 0;
            if (t[c]) begin
                m_trip[c] = 1; m_gate[c] = 0;
            end else if (m_trip[c] == 1) begin
                if (rise == 1) begin m_trip[c] = 0; m_gate[c] = 1; end
                else m_gate[c] = 0;
            end else begin
                m_gate[c] = i[c] ? 1 : 0;
            end
            if (!i[c] && o[c]) m_ol[c] = 1;
            else if (fall == 1) m_ol[c] = 0;
            m_q[c] = i[c] ? 1 : 0;
        end
    endfunction

    task automatic compare(string tag);
        logic [3:0] eg;
        logic [7:0] ev;
        for (int c = 0; c < 4; c++) begin
            eg[c] = (m_gate[c] == 1);
            ev[c] = (m_trip[c] == 1);
            ev[4+c] = (m_ol[c] == 1);
        end
        vectors++;
        if (gate_en !== eg || fault_vec !== ev) begin
            errors++;
            $display("FAIL %s: gate_en=%b fault_vec=%b expected gate_en=%b fault_vec=%b",
                     tag, gate_en, fault_vec, eg, ev);
        end
    endtask

    task automatic step(logic [3:0] i, logic [3:0] t, logic [3:0] o, string tag);
        ch_in = i; ot_sense = t; ol_sense = o;
        @(posedge clk);
        model_tick(i, t, o);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ch_in = 4'hF; ot_sense = 4'hF; ol_sense = 4'hF;
        model_clear();
        @(posedge clk);
        @(negedge clk);
        compare("R1");
        @(negedge clk);
        compare("R1");
        ch_in = '0; ot_sense = '0; ol_sense = '0;
        rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        model_clear();
        do_reset();
        // R2: gate follows command
        step(4'b0001, 0, 0, "R2");
        step(4'b0011, 0, 0, "R2");
        step(4'b1010, 0, 0, "R2");
        step(4'b0000, 0, 0, "R2");
        // R3: trip while on, then while off
        step(4'b0001, 0, 0, "R2");
        step(4'b0001, 4'b0001, 0, "R3");
        step(4'b0001, 0, 0, "R4");
        step(4'b0001, 0, 0, "R4");
        step(4'b0000, 4'b0010, 0, "R3");
        // R4: held until rising edge
        step(4'b0000, 0, 0, "R4");
        step(4'b0011, 0, 0, "R4");
        step(4'b0011, 0, 0, "R4");
        // R5: rise and trip in the same cycle
        step(4'b0000, 0, 0, "R2");
        step(4'b0001, 4'b0001, 0, "R5");
        step(4'b0001, 0, 0, "R5");
        step(4'b0000, 0, 0, "R4");
        step(4'b0001, 0, 0, "R4");
        // R6: open-load ignored while high, set while low
        step(4'b0100, 0, 4'b0100, "R6");
        step(4'b0100, 0, 0, "R6");
        step(4'b0000, 0, 0, "R7");
        step(4'b0000, 0, 4'b0100, "R6");
        step(4'b0000, 0, 0, "R6");
        // R8: open-load flag does not block gate
        step(4'b0100, 0, 0, "R8");
        step(4'b0100, 0, 0, "R8");
        // R7: falling edge clears; same-cycle sense keeps it
        step(4'b0000, 0, 0, "R7");
        step(4'b0000, 0, 4'b1000, "R6");
        step(4'b1000, 0, 0, "R8");
        step(4'b0000, 0, 4'b1000, "R7");
        step(4'b1000, 0, 0, "R7");
        step(4'b0000, 0, 0, "R7");
        // R9: one channel trips while others toggle
        step(4'b1111, 4'b0100, 0, "R9");
        step(4'b1011, 0, 0, "R9");
        step(4'b1111, 0, 0, "R9");
        step(4'b0000, 0, 0, "R9");
        // R1: reset in the middle of activity
        step(4'b0000, 4'b0011, 4'b1100, "R10");
        do_reset();
        // R10: pseudo-random traffic on all channels
        for (int n = 0; n < 400; n++) begin
            logic [3:0] ri, rt, ro;
            ri = 4'($urandom);
            rt = 4'($urandom) & 4'($urandom) & 4'($urandom);
            ro = 4'($urandom) & 4'($urandom);
            step(ri, rt, ro, "R10");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule